// File: doc/BRIEF.md
# Slewing Time-of-Day Counter

This block is the free-running time base of a precision-time-protocol clock. It holds a nanoseconds field and a seconds field. On every clock it adds a programmable increment to the nanoseconds field. The nanoseconds field wraps at one billion and carries into the seconds field. Software reaches the block through a small register port: a write strobe, a read strobe, an address, write data and combinational read data.

Software has two ways to correct the time.

- **Step correction.** For a coarse error, software loads either time field directly.
- **Slew correction.** For a small offset, software writes a signed magnitude. The block then lengthens or shortens each following tick by exactly 1 ns until the magnitude is spent. It then raises a sticky completion flag that software can poll and clear.

Because the time is never read, modified and written back, no software latency can leak into the result.

Top module: `ptp_slew_clock`

## Requirements
- R1: While reset is held, the time reads zero seconds and zero nanoseconds, the increment reads 8, and the done and busy flags are 0.
- R2: On each clock without a time-field write, the time advances by the increment. The nanoseconds field wraps at 1,000,000,000 and carries one into the seconds field.
- R3: A write to address 0 loads the nanoseconds field from wdata[29:0]. A value of 1,000,000,000 or more loads 999,999,999. A write to address 1 loads the seconds field. The counter does not advance in that cycle. Either write cancels a pending slew, so busy goes to 0 and the remaining magnitude reads 0. The done flag is left as it is.
- R4: Address 2 holds the increment in wdata[INC_W-1:0] and reads it back.
- R5: A write to address 3 starts a slew. Bit 31 is the direction (0 adds, 1 subtracts) and bits 29:0 are the magnitude N. The write clears done and sets busy. In each of the next N clocks the time advances by the increment plus or minus 1 ns, and the remaining magnitude drops by one. Address 3 reads {direction, 0, remaining}, so bit 30 always reads 0.
- R6: Subtracting at zero nanoseconds borrows: the nanoseconds field becomes 999,999,999 and the seconds field decrements.
- R7: One clock after the remaining magnitude reaches zero (N+1 clocks after the write), done is set and busy clears. A magnitude of zero sets done on the first clock after the write.
- R8: Address 4 reads done in bit 0 and busy in bit 1. Writing 1 to bit 0 clears done. Writing 0 has no effect. The adj_done and adj_busy pins follow the flags.
- R9: When a slew completes in the same cycle that software writes 1 to clear done, done ends up set.
- R10: A write to address 3 while a slew is busy replaces the remaining magnitude and direction and restarts the count. The tick in which the write lands still carries the old correction.
- R11: A read strobe at address 0 captures the seconds field at that clock edge. Address 1 reads back the captured seconds, not the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the seconds capture) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| time_ns | output | 30 | Live nanoseconds field |
| time_sec | output | SEC_W | Live seconds field |
| adj_done | output | 1 | Sticky slew completion flag |
| adj_busy | output | 1 | Slew in progress |

## Verification
Two pairs of events can fall on the same edge.

- **Completion and software clear.** A slew can finish in the same cycle that software writes 1 to clear done. The bench starts a two-nanosecond slew and counts edges so that the clear lands exactly on the completing edge. The check then expects done to read 1 rather than 0.
- **Corrected tick and restart.** A new slew write can land on a tick that is still being corrected. The bench restarts a running slew and compares the total elapsed time against its count of corrected ticks. That count includes the tick carrying the restart.

The borrow below zero is provoked with a zero increment, so that the subtraction alone crosses the second boundary.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
  localparam int NS_W   = 30;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_NSEC  = 3'd0,
    RA_SEC   = 3'd1,
    RA_INC   = 3'd2,
    RA_SLEW  = 3'd3,
    RA_FLAGS = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_PLUS  = 2'd1,
    CORR_MINUS = 2'd2
  } corr_e;

endpackage

// File: rtl/ptpc_step_unit.sv
module ptpc_step_unit
  import ptpc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int INC_W = 8
) (
  input  logic [NS_W-1:0]  cur_ns,
  input  logic [SEC_W-1:0] cur_sec,
  input  logic [INC_W-1:0] inc,
  input  corr_e            corr,
  output logic [NS_W-1:0]  nxt_ns,
  output logic [SEC_W-1:0] nxt_sec
);

  localparam int SUM_W = 32;

  logic [SUM_W-1:0] sum;
  logic             plus, minus, borrow, carry;

  always_comb begin
    plus   = (corr == CORR_PLUS);
    minus  = (corr == CORR_MINUS);
    sum    = SUM_W'(cur_ns) + SUM_W'(inc) + SUM_W'(plus);
    borrow = 1'b0;
    carry  = 1'b0;
    if (minus) begin
      if (sum == '0) borrow = 1'b1;
      else           sum = sum - SUM_W'(1);
    end
    if (!borrow && (sum >= NS_PER_SEC)) begin
      carry = 1'b1;
      sum   = sum - NS_PER_SEC;
    end
    nxt_ns  = borrow ? NS_W'(NS_PER_SEC - 32'd1) : sum[NS_W-1:0];
    nxt_sec = borrow ? (cur_sec - SEC_W'(1)) : (cur_sec + SEC_W'(carry));
  end

endmodule

// File: rtl/ptpc_tod_reg.sv
module ptpc_tod_reg
  import ptpc_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ns,
  input  logic             ld_sec,
  input  logic [31:0]      ld_val,
  input  logic [NS_W-1:0]  nxt_ns,
  input  logic [SEC_W-1:0] nxt_sec,
  output logic [NS_W-1:0]  ns_q,
  output logic [SEC_W-1:0] sec_q
);

  logic [NS_W-1:0] ns_load;

  always_comb begin
    if (32'(ld_val[NS_W-1:0]) >= NS_PER_SEC) ns_load = NS_W'(NS_PER_SEC - 32'd1);
    else                                     ns_load = ld_val[NS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (ld_ns) begin
      ns_q  <= ns_load;
    end else if (ld_sec) begin
      sec_q <= ld_val[SEC_W-1:0];
    end else begin
      ns_q  <= nxt_ns;
      sec_q <= nxt_sec;
    end
  end

endmodule

// File: rtl/ptpc_slew_ctrl.sv
module ptpc_slew_ctrl
  import ptpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_neg,
  input  logic [NS_W-1:0] start_mag,
  input  logic            cancel,
  input  logic            clr_done,
  output logic            active_q,
  output logic            neg_q,
  output logic [NS_W-1:0] rem_q,
  output logic            done_q,
  output corr_e           corr
);

  logic finish;

  assign finish = active_q && (rem_q == '0);

  always_comb begin
    if (active_q && (rem_q != '0)) corr = neg_q ? CORR_MINUS : CORR_PLUS;
    else                           corr = CORR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      neg_q    <= 1'b0;
      rem_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      neg_q    <= start_neg;
      rem_q    <= start_mag;
    end else if (cancel) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (active_q) begin
      if (finish) active_q <= 1'b0;
      else        rem_q    <= rem_q - NS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done_q <= 1'b0;
    else if (start)              done_q <= 1'b0;
    else if (finish && !cancel)  done_q <= 1'b1;
    else if (clr_done)           done_q <= 1'b0;
  end

endmodule

// File: rtl/ptpc_reg_if.sv
module ptpc_reg_if
  import ptpc_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int INC_W   = 8,
  parameter int INC_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [INC_W-1:0]  inc_wdata,
  input  logic              flag_wbit,
  input  logic [NS_W-1:0]   ns_q,
  input  logic [SEC_W-1:0]  sec_q,
  input  logic              active_q,
  input  logic              neg_q,
  input  logic [NS_W-1:0]   rem_q,
  input  logic              done_q,
  output logic [INC_W-1:0]  inc_q,
  output logic              ld_ns,
  output logic              ld_sec,
  output logic              slew_wr,
  output logic              clr_done,
  output logic [31:0]       reg_rdata
);

  logic [SEC_W-1:0] sec_snap;

  assign ld_ns    = reg_wr && (reg_addr == RA_NSEC);
  assign ld_sec   = reg_wr && (reg_addr == RA_SEC);
  assign slew_wr  = reg_wr && (reg_addr == RA_SLEW);
  assign clr_done = reg_wr && (reg_addr == RA_FLAGS) && flag_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                inc_q <= INC_W'(INC_RST);
    else if (reg_wr && (reg_addr == RA_INC))   inc_q <= inc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sec_snap <= '0;
    else if (reg_rd && (reg_addr == RA_NSEC))  sec_snap <= sec_q;
  end

  always_comb begin
    case (reg_addr)
      RA_NSEC:  reg_rdata = 32'(ns_q);
      RA_SEC:   reg_rdata = 32'(sec_snap);
      RA_INC:   reg_rdata = 32'(inc_q);
      RA_SLEW:  reg_rdata = {neg_q, 1'b0, rem_q};
      RA_FLAGS: reg_rdata = {30'd0, active_q, done_q};
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ptp_slew_clock.sv
module ptp_slew_clock
  import ptpc_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int INC_W   = 8,
  parameter int INC_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [29:0]      time_ns,
  output logic [SEC_W-1:0] time_sec,
  output logic             adj_done,
  output logic             adj_busy
);

  logic [INC_W-1:0] inc_q;
  logic             ld_ns, ld_sec, slew_wr, clr_done;
  logic             slew_active, slew_neg, slew_done;
  logic [NS_W-1:0]  slew_rem;
  corr_e            corr;
  logic [NS_W-1:0]  nxt_ns;
  logic [SEC_W-1:0] nxt_sec;

  ptpc_reg_if #(.SEC_W(SEC_W), .INC_W(INC_W), .INC_RST(INC_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .inc_wdata (reg_wdata[INC_W-1:0]),
    .flag_wbit (reg_wdata[0]),
    .ns_q      (time_ns),
    .sec_q     (time_sec),
    .active_q  (slew_active),
    .neg_q     (slew_neg),
    .rem_q     (slew_rem),
    .done_q    (slew_done),
    .inc_q     (inc_q),
    .ld_ns     (ld_ns),
    .ld_sec    (ld_sec),
    .slew_wr   (slew_wr),
    .clr_done  (clr_done),
    .reg_rdata (reg_rdata)
  );

  ptpc_slew_ctrl u_slew (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (slew_wr),
    .start_neg (reg_wdata[31]),
    .start_mag (reg_wdata[NS_W-1:0]),
    .cancel    (ld_ns | ld_sec),
    .clr_done  (clr_done),
    .active_q  (slew_active),
    .neg_q     (slew_neg),
    .rem_q     (slew_rem),
    .done_q    (slew_done),
    .corr      (corr)
  );

  ptpc_step_unit #(.SEC_W(SEC_W), .INC_W(INC_W)) u_step (
    .cur_ns  (time_ns),
    .cur_sec (time_sec),
    .inc     (inc_q),
    .corr    (corr),
    .nxt_ns  (nxt_ns),
    .nxt_sec (nxt_sec)
  );

  ptpc_tod_reg #(.SEC_W(SEC_W)) u_tod (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_ns   (ld_ns),
    .ld_sec  (ld_sec),
    .ld_val  (reg_wdata),
    .nxt_ns  (nxt_ns),
    .nxt_sec (nxt_sec),
    .ns_q    (time_ns),
    .sec_q   (time_sec)
  );

  assign adj_done = slew_done;
  assign adj_busy = slew_active;

endmodule

// File: rtl/ptp_slew_clock_chk.sv
module ptp_slew_clock_chk
  import ptpc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int INC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             wbit0,
  input logic [NS_W-1:0]  time_ns,
  input logic [SEC_W-1:0] time_sec,
  input logic [INC_W-1:0] inc_q,
  input logic             active,
  input logic [NS_W-1:0]  rem,
  input logic             done
);

  // R2: nanoseconds never reach one second
  assert_ns_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(time_ns) < NS_PER_SEC);

  // R2: plain advance without wrap or correction
  assert_plain_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !active && (32'(time_ns) + 32'(inc_q) < NS_PER_SEC))
    |=> (32'(time_ns) == $past(32'(time_ns) + 32'(inc_q))) && $stable(time_sec));

  // R3: a time-field write cancels the slew
  assert_time_write_cancels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1)) |=> !active);

  // R5: the remaining magnitude counts down by one per tick
  assert_rem_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (rem != '0) && !reg_wr) |=> (rem == $past(rem) - NS_W'(1)));

  // R5: a slew write clears done and arms the slew
  assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3) |=> (!done && active));

  // R7: exhausting the magnitude raises done and drops busy
  assert_finish_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (rem == '0) && !reg_wr) |=> (done && !active));

  // R8: clearing works when no completion coincides
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && wbit0 && !(active && rem == '0)) |=> !done);

  // R9: a completion wins over a concurrent clear
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && wbit0 && active && rem == '0) |=> done);

endmodule

bind ptp_slew_clock ptp_slew_clock_chk #(.SEC_W(SEC_W), .INC_W(INC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .wbit0    (reg_wdata[0]),
  .time_ns  (time_ns),
  .time_sec (time_sec),
  .inc_q    (inc_q),
  .active   (slew_active),
  .rem      (slew_rem),
  .done     (slew_done)
);

// File: tb/test_ptp_slew_clock.sv
module test_ptp_slew_clock;

  localparam logic [2:0] A_NS = 3'd0, A_SEC = 3'd1, A_INC = 3'd2, A_ADJ = 3'd3, A_FLG = 3'd4;
  localparam longint BILLION = 64'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [29:0] time_ns;
  logic [31:0] time_sec;
  logic        adj_done, adj_busy;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ptp_slew_clock i_ptp_slew_clock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns), .time_sec(time_sec),
    .adj_done(adj_done), .adj_busy(adj_busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint now_total();
    return longint'(time_sec) * BILLION + longint'(time_ns);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_cap(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] n);
    wr(A_NS, n);
    wr(A_SEC, s);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ns", time_ns, 0);
    chk("R1 sec", time_sec, 0);
    rd(A_INC, d); chk("R1 increment", d, 8);
    rd(A_FLG, d); chk("R1 flags", d, 0);
    chk("R1 pins", {adj_busy, adj_done}, 0);
  endtask

  task automatic t_run();
    set_time(5, 100);
    chk("R3 load", now_total(), 5 * BILLION + 100);
    idle(10);
    chk("R2 advance", now_total(), 5 * BILLION + 180);
    set_time(3, 999_999_995);
    idle(1);
    chk("R2 wrap ns", time_ns, 3);
    chk("R2 wrap sec", time_sec, 4);
  endtask

  task automatic t_clamp();
    set_time(9, 0);
    wr(A_NS, 32'h3FFF_FFFF);
    chk("R3 clamp ns", time_ns, 999_999_999);
    chk("R3 sec held", time_sec, 9);
  endtask

  task automatic t_inc();
    logic [31:0] d;
    wr(A_INC, 3);
    rd(A_INC, d); chk("R4 readback", d, 3);
    set_time(1, 0);
    idle(4);
    chk("R4 step 3", now_total(), BILLION + 12);
    wr(A_INC, 8);
  endtask

  task automatic t_slew_pos();
    logic [31:0] d;
    longint base;
    set_time(10, 1000);
    base = now_total();
    wr(A_ADJ, 5);
    chk("R5 write tick plain", now_total(), base + 8);
    chk("R5 busy", adj_busy, 1);
    rd(A_ADJ, d); chk("R5 remaining loaded", d, 5);
    idle(2);
    rd(A_ADJ, d); chk("R5 remaining 3", d, 3);
    idle(3);
    chk("R5 plus corrected", now_total(), base + 8 + 5 * 9);
    chk("R7 not done yet", adj_done, 0);
    idle(1);
    chk("R7 done", adj_done, 1);
    chk("R7 busy clear", adj_busy, 0);
    chk("R5 back to plain", now_total(), base + 61);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    rd(A_FLG, d); chk("R8 flags read", d, 1);
    wr(A_FLG, 0);
    chk("R8 write zero ignored", adj_done, 1);
    wr(A_FLG, 1);
    chk("R8 w1c", adj_done, 0);
  endtask

  task automatic t_borrow();
    logic [31:0] d;
    wr(A_INC, 0);
    set_time(2, 1);
    wr(A_ADJ, 32'h8000_0003);
    rd(A_ADJ, d); chk("R5 sign readback", d, 32'h8000_0003);
    chk("R6 write tick", now_total(), 2 * BILLION + 1);
    idle(1);
    chk("R6 minus to zero", time_ns, 0);
    idle(1);
    chk("R6 borrow ns", time_ns, 999_999_999);
    chk("R6 borrow sec", time_sec, 1);
    idle(1);
    chk("R6 after borrow", now_total(), BILLION + 999_999_998);
    idle(1);
    chk("R7 done after minus", adj_done, 1);
    chk("R6 held at zero increment", now_total(), BILLION + 999_999_998);
    wr(A_INC, 8);
  endtask

  task automatic t_zero();
    wr(A_ADJ, 0);
    chk("R5 write clears done", adj_done, 0);
    idle(1);
    chk("R7 zero magnitude done", adj_done, 1);
  endtask

  task automatic t_collide();
    wr(A_ADJ, 2);
    idle(2);
    wr(A_FLG, 1);
    chk("R9 set wins over clear", adj_done, 1);
    wr(A_FLG, 1);
    chk("R8 later clear", adj_done, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    set_time(20, 0);
    wr(A_ADJ, 10);
    idle(3);
    wr(A_ADJ, 2);
    chk("R10 done cleared", adj_done, 0);
    rd(A_ADJ, d); chk("R10 new magnitude", d, 2);
    idle(3);
    chk("R10 done", adj_done, 1);
    chk("R10 total correction", now_total(), 20 * BILLION + 70);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    wr(A_ADJ, 100);
    idle(2);
    wr(A_NS, 500);
    chk("R3 ns loaded", time_ns, 500);
    chk("R3 busy cancelled", adj_busy, 0);
    rd(A_ADJ, d); chk("R3 remaining zero", d, 0);
    idle(120);
    chk("R3 no done after cancel", adj_done, 0);
    chk("R3 plain after cancel", time_ns, 500 + 120 * 8);
  endtask

  task automatic t_bit30();
    logic [31:0] d;
    wr(A_ADJ, 32'h7FFF_FFFF);
    rd(A_ADJ, d); chk("R5 bit30 zero", d, 32'h3FFF_FFFF);
    wr(A_SEC, 0);
  endtask

  task automatic t_snap();
    logic [31:0] d;
    set_time(7, 999_999_990);
    rd_cap(A_NS, d); chk("R11 ns read", d, 999_999_990);
    idle(1);
    chk("R11 live sec", time_sec, 8);
    rd(A_SEC, d); chk("R11 captured sec", d, 7);
    rd_cap(A_NS, d);
    rd(A_SEC, d); chk("R11 recapture", d, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_run();
    t_clamp();
    t_inc();
    t_slew_pos();
    t_flags();
    t_borrow();
    t_zero();
    t_collide();
    t_restart();
    t_cancel();
    t_bit30();
    t_snap();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule